// File: doc/BRIEF.md
# Two-Channel Byte Mover with Video Block Counting

This block moves single bytes between peripherals and a 32-bit word memory whose bytes are numbered big-endian. It has two channels. Channel 0 serves a disk-style peripheral through a byte strobe handshake. Channel 1 feeds a display refresh. That refresh is counted in 64-byte blocks, and the channel can restart its count and its address by itself. Software programs each channel through a small register bus. The fields it sets are an 8-bit control field in the upper byte of a mode word, a load address and a block count. It can read back the current address, the mode word and a reload shadow of the count.

A granted transfer completes in the cycle it is granted. Memory read data and peripheral read data are taken combinationally in that cycle, and the current address steps at the next clock edge. Only one channel moves a byte per cycle. A frame-start pulse tells the video channel to restore its count, or to force the count to zero while auto-reload is off. A blanking output shows whether the display would receive refresh data.

Top module: `bytemover_dma2`

## Requirements
- R1: After reset every mode word, address, block count and reload count reads zero, no strobe is active and `vid_blank` is high.
- R2: A mode write (index 0) changes only bits 31:24. Bits 23:0 always read zero. Bit 31 enables the channel, bit 30 selects peripheral-to-memory when 1 and memory-to-peripheral when 0, and bit 29 enables auto-reload.
- R3: A mode write with bit 31 set copies the load address (index 1) into the current address (index 2, read-only) and restarts the channel's 64-byte block position.
- R4: A block-count write (index 3) also writes the reload count (index 4, read-only) with the same value.
- R5: Each cycle in which a channel is granted moves one byte, and the current address is one higher after the next clock edge.
- R6: Peripheral-to-memory asserts that channel's `per_rd_stb` bit and writes `per_rdata` into memory. Memory-to-peripheral asserts its `per_wr_stb` bit and presents the memory byte on `per_wdata`.
- R7: Byte address A uses lane (A[1:0] XOR 3), so byte address 4k+0 sits in bits 31:24 of word k. `mem_be` has exactly that one lane set, and written bytes are replicated on all four lanes of `mem_wdata`.
- R8: While a channel's enable bit is clear, its request is ignored: no strobe and no address change.
- R9: When both channels request and both are enabled, channel 0 is served and channel 1 waits.
- R10: On channel 1, every 64th transferred byte ends a block and decrements a non-zero count. If the count goes from 1 to 0 with auto-reload on, the count is taken from the reload count and the current address from the load address.
- R11: A `vid_frame` pulse on enabled channel 1 sets its count to the reload count if auto-reload is on, and to zero otherwise. `vid_blank` is low exactly while channel 1 has both enable and auto-reload set.
- R12: A count read on channel 0, or on channel 1 while channel 1 is disabled, returns channel 0's count. Otherwise it returns channel 1's count. Register address bit 3 selects the channel and bits 2:0 select the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bit 3 channel, bits 2:0 register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| dma_req | input | 2 | Per-channel transfer request |
| per_rdata | input | 16 | Peripheral bytes, channel c in bits 8c+7:8c |
| per_rd_stb | output | 2 | Byte taken from peripheral c this cycle |
| per_wr_stb | output | 2 | Byte given to peripheral c this cycle |
| per_wdata | output | 8 | Byte for the peripheral |
| mem_addr | output | 14 | Memory word address |
| mem_be | output | 4 | Byte lane enables |
| mem_we | output | 1 | Memory write |
| mem_re | output | 1 | Memory read |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| vid_frame | input | 1 | Frame start pulse for channel 1 |
| vid_blank | output | 1 | Display blanked |

## Verification
The assertions take for granted that memory returns read data in the cycle `mem_re` is high, and that `per_rdata` is valid whenever a read strobe is active. They also assume software does not write the mode word of a channel in a cycle where it expects that channel's address to step. The stimulus changes every input just after a rising edge. It holds requests only for counted cycles, sets register writes apart from requests on the same channel, and models memory as a combinational array. The frame pulse is given on its own, one cycle long, between bursts of requests.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam int NCH         = 2;
  localparam int VID_CH      = 1;
  localparam int MODE_EN     = 31;
  localparam int MODE_TOMEM  = 30;
  localparam int MODE_AUTO   = 29;
  localparam int MODE_WR_LSB = 24;
  localparam int BLK_BYTES   = 64;

  typedef enum logic [2:0] {
    RI_MODE   = 3'd0,
    RI_LOAD   = 3'd1,
    RI_CUR    = 3'd2,
    RI_COUNT  = 3'd3,
    RI_RELOAD = 3'd4
  } reg_idx_e;

  // big-endian lane of a byte address within its word
  function automatic logic [1:0] be_lane(input logic [1:0] a);
    return a ^ 2'b11;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] a);
    return 4'b0001 << be_lane(a);
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] a);
    return w[8*be_lane(a) +: 8];
  endfunction

  // only the control byte takes write data, status bits keep their value
  function automatic logic [31:0] mode_merge(input logic [31:0] old, input logic [31:0] wd);
    return {wd[31:MODE_WR_LSB], old[MODE_WR_LSB-1:0]};
  endfunction
endpackage

// File: rtl/bdma_arb.sv
module bdma_arb #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] en,
  output logic [NCH-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && en[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bdma_chan.sv
module bdma_chan
  import bdma_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter bit IS_VIDEO = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic          wr_load,
  input  logic          wr_count,
  input  logic [31:0]   wdata,
  input  logic          xfer,
  input  logic          frame,
  output logic [31:0]   mode_o,
  output logic [AW-1:0] load_o,
  output logic [AW-1:0] cur_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] reload_o,
  output logic          blk_done_o
);
  localparam int BW = $clog2(BLK_BYTES);

  logic [31:0]   mode_q;
  logic [AW-1:0] load_q, cur_q;
  logic [CW-1:0] count_q, reload_q;
  logic          en, auto_rl, arm;
  logic          blk_done, frame_hit, wrap;
  logic          unused_wd;

  assign en        = mode_q[MODE_EN];
  assign auto_rl   = mode_q[MODE_AUTO];
  assign arm       = wr_mode && wdata[MODE_EN];
  assign unused_wd = ^wdata;

  generate
    if (IS_VIDEO) begin : g_video
      logic [BW-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   byte_q <= '0;
        else if (arm || (frame && en)) byte_q <= '0;
        else if (xfer)                byte_q <= byte_q + 1'b1;
      end
      assign blk_done  = xfer && (byte_q == BW'(BLK_BYTES-1));
      assign frame_hit = frame && en;
    end else begin : g_plain
      logic unused_frame;
      assign unused_frame = frame;
      assign blk_done     = 1'b0;
      assign frame_hit    = 1'b0;
    end
  endgenerate

  assign wrap = blk_done && auto_rl && (count_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      load_q   <= '0;
      cur_q    <= '0;
      count_q  <= '0;
      reload_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_merge(mode_q, wdata);
      if (wr_load) load_q <= wdata[AW-1:0];

      if (arm || wrap) cur_q <= load_q;
      else if (xfer)   cur_q <= cur_q + 1'b1;

      if (wr_count) begin
        count_q  <= wdata[CW-1:0];
        reload_q <= wdata[CW-1:0];
      end else if (frame_hit) begin
        count_q <= auto_rl ? reload_q : '0;
      end else if (wrap) begin
        count_q <= reload_q;
      end else if (blk_done && (count_q != '0)) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assign mode_o     = mode_q;
  assign load_o     = load_q;
  assign cur_o      = cur_q;
  assign count_o    = count_q;
  assign reload_o   = reload_q;
  assign blk_done_o = blk_done;
endmodule

// File: rtl/bdma_port.sv
module bdma_port
  import bdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int NCH = 2
) (
  input  logic [NCH-1:0]         grant,
  input  logic [NCH-1:0]         tomem,
  input  logic [NCH-1:0][AW-1:0] cur,
  input  logic [NCH-1:0][7:0]    per_byte,
  input  logic [31:0]            mem_rdata,
  output logic [AW-3:0]          mem_addr,
  output logic [3:0]             mem_be,
  output logic                   mem_we,
  output logic                   mem_re,
  output logic [31:0]            mem_wdata,
  output logic [NCH-1:0]         rd_stb,
  output logic [NCH-1:0]         wr_stb,
  output logic [7:0]             wr_byte
);
  logic [AW-1:0] sel_addr;
  logic          sel_tomem, active;
  logic [7:0]    sel_byte;

  always_comb begin
    sel_addr  = '0;
    sel_tomem = 1'b0;
    sel_byte  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        sel_addr  = cur[i];
        sel_tomem = tomem[i];
        sel_byte  = per_byte[i];
      end
    end
  end

  assign active    = |grant;
  assign mem_addr  = sel_addr[AW-1:2];
  assign mem_be    = active ? lane_mask(sel_addr[1:0]) : 4'b0000;
  assign mem_we    = active && sel_tomem;
  assign mem_re    = active && !sel_tomem;
  assign mem_wdata = {4{sel_byte}};
  assign wr_byte   = lane_pick(mem_rdata, sel_addr[1:0]);
  assign rd_stb    = grant & tomem;
  assign wr_stb    = grant & ~tomem;
endmodule

// File: rtl/bytemover_dma2.sv
module bytemover_dma2
  import bdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [1:0]    dma_req,
  input  logic [15:0]   per_rdata,
  output logic [1:0]    per_rd_stb,
  output logic [1:0]    per_wr_stb,
  output logic [7:0]    per_wdata,
  output logic [AW-3:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic          mem_we,
  output logic          mem_re,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          vid_frame,
  output logic          vid_blank
);
  logic                   ch;
  reg_idx_e               idx;
  logic [NCH-1:0]         wr_mode, wr_load, wr_count, xfer, en, tomem, blk_done;
  logic [NCH-1:0][31:0]   mode_q;
  logic [NCH-1:0][AW-1:0] load_q, cur_q;
  logic [NCH-1:0][CW-1:0] count_q, reload_q;
  logic [NCH-1:0][7:0]    per_byte;

  assign ch  = reg_addr[3];
  assign idx = reg_idx_e'(reg_addr[2:0]);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit         = reg_wr && (ch == c[0]);
      assign wr_mode[c]  = hit && (idx == RI_MODE);
      assign wr_load[c]  = hit && (idx == RI_LOAD);
      assign wr_count[c] = hit && (idx == RI_COUNT);
      assign en[c]       = mode_q[c][MODE_EN];
      assign tomem[c]    = mode_q[c][MODE_TOMEM];
      assign per_byte[c] = per_rdata[8*c +: 8];

      bdma_chan #(.AW(AW), .CW(CW), .IS_VIDEO(c == VID_CH)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .wr_mode(wr_mode[c]), .wr_load(wr_load[c]), .wr_count(wr_count[c]),
        .wdata(reg_wdata), .xfer(xfer[c]), .frame(vid_frame),
        .mode_o(mode_q[c]), .load_o(load_q[c]), .cur_o(cur_q[c]),
        .count_o(count_q[c]), .reload_o(reload_q[c]), .blk_done_o(blk_done[c])
      );
    end
  endgenerate

  bdma_arb #(.NCH(NCH)) u_arb (.req(dma_req), .en(en), .grant(xfer));

  bdma_port #(.AW(AW), .NCH(NCH)) u_port (
    .grant(xfer), .tomem(tomem), .cur(cur_q), .per_byte(per_byte),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .rd_stb(per_rd_stb), .wr_stb(per_wr_stb), .wr_byte(per_wdata)
  );

  always_comb begin
    unique case (idx)
      RI_MODE:   reg_rdata = mode_q[ch];
      RI_LOAD:   reg_rdata = 32'(load_q[ch]);
      RI_CUR:    reg_rdata = 32'(cur_q[ch]);
      RI_COUNT:  reg_rdata = (!ch || !en[VID_CH]) ? 32'(count_q[0]) : 32'(count_q[VID_CH]);
      RI_RELOAD: reg_rdata = 32'(reload_q[ch]);
      default:   reg_rdata = '0;
    endcase
  end

  assign vid_blank = !(en[VID_CH] && mode_q[VID_CH][MODE_AUTO]);
endmodule

// File: rtl/bdma_chk.sv
module bdma_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           dma_req,
  input logic [31:0]          reg_wdata,
  input logic [1:0]           wr_mode,
  input logic [1:0]           wr_count,
  input logic [1:0]           xfer,
  input logic [1:0][31:0]     mode_q,
  input logic [1:0][AW-1:0]   load_q,
  input logic [1:0][AW-1:0]   cur_q,
  input logic [1:0][CW-1:0]   reload_q,
  input logic [1:0]           per_rd_stb,
  input logic [1:0]           per_wr_stb,
  input logic                 mem_we,
  input logic                 mem_re,
  input logic [3:0]           mem_be
);
  // R2
  mode_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode[0] |=> mode_q[0][31:24] == $past(reg_wdata[31:24]));

  // R3
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode[0] && reg_wdata[31]) |=> cur_q[0] == $past(load_q[0]));

  // R4
  reload_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count[1] |=> reload_q[1] == $past(reg_wdata[CW-1:0]));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer[0] && !wr_mode[0]) |=> cur_q[0] == $past(cur_q[0]) + 1'b1);

  // R6
  dir_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(per_rd_stb) == 1 && per_wr_stb == 2'b00));

  // R7
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> $countones(mem_be) == 1);

  // R8
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1][31] |-> !(per_rd_stb[1] || per_wr_stb[1]));

  // R9
  ch0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req[0] && mode_q[0][31]) |-> !(per_rd_stb[1] || per_wr_stb[1]));
endmodule

bind bytemover_dma2 bdma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .reg_wdata(reg_wdata),
  .wr_mode(wr_mode), .wr_count(wr_count), .xfer(xfer),
  .mode_q(mode_q), .load_q(load_q), .cur_q(cur_q), .reload_q(reload_q),
  .per_rd_stb(per_rd_stb), .per_wr_stb(per_wr_stb),
  .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be)
);

// File: tb/test_bytemover_dma2.sv
module test_bytemover_dma2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dma_req = '0;
  logic [15:0] per_rdata = '0;
  logic [1:0]  per_rd_stb, per_wr_stb;
  logic [7:0]  per_wdata;
  logic [13:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re;
  logic [31:0] mem_wdata, mem_rdata;
  logic        vid_frame = 1'b0;
  logic        vid_blank;

  int checks = 0;
  int failures = 0;
  int st0 = 0;
  bit done = 1'b0;
  logic [7:0]  exp_q[$];
  logic [31:0] mem [64];
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  bytemover_dma2 i_bytemover_dma2 (.*);

  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk)
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr[5:0]][8*i +: 8] <= mem_wdata[8*i +: 8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for channel 0 bytes sent to the peripheral
  always @(negedge clk) begin
    if (rst_n && (per_rd_stb[0] || per_wr_stb[0])) st0++;
    if (rst_n && per_wr_stb[0]) begin
      if (exp_q.size() == 0) chk("R6 unexpected ch0 byte", {24'h0, per_wdata}, 32'hxx);
      else chk("R7 ch0 byte lane", {24'h0, per_wdata}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[4] = 32'h11223344;
    repeat (3) tick();
    // R1 reset state
    chk("R1 blank", {31'h0, vid_blank}, 32'h1);
    chk("R1 strobes", {28'h0, per_rd_stb, per_wr_stb}, 32'h0);
    rst_n = 1'b1;
    tick();
    rd(4'h0, rv); chk("R1 mode0", rv, 0);
    rd(4'hA, rv); chk("R1 cur1", rv, 0);
    rd(4'hC, rv); chk("R1 reload1", rv, 0);

    // R2 only the control byte is written
    wr(4'h0, 32'h5A12_3456);
    rd(4'h0, rv); chk("R2 mode mask", rv, 32'h5A00_0000);

    // R3 enable copies load address
    wr(4'h1, 32'h10);
    wr(4'h0, 32'h8000_0000);
    rd(4'h2, rv); chk("R3 cur from load", rv, 32'h10);

    // R5 R6 R7 memory to peripheral, big-endian bytes
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    exp_q.push_back(8'h33); exp_q.push_back(8'h44);
    dma_req = 2'b01;
    repeat (4) tick();
    dma_req = 2'b00;
    rd(4'h2, rv); chk("R5 cur after 4", rv, 32'h14);
    chk("R6 all bytes seen", exp_q.size(), 0);
    chk("R6 ch0 strobe count", st0, 4);

    // R8 disabled channel ignores request
    wr(4'h0, 32'h4000_0000);
    dma_req = 2'b01;
    repeat (3) tick();
    dma_req = 2'b00;
    chk("R8 no strobes", st0, 4);
    rd(4'h2, rv); chk("R8 cur held", rv, 32'h14);

    // R6 R7 peripheral to memory
    wr(4'h1, 32'h20);
    wr(4'h0, 32'hC000_0000);
    dma_req = 2'b01;
    per_rdata[7:0] = 8'hA1; tick();
    per_rdata[7:0] = 8'hB2; tick();
    per_rdata[7:0] = 8'hC3; tick();
    dma_req = 2'b00;
    chk("R7 mem word", mem[8], 32'hA1B2_C300);

    // R9 channel 0 wins
    wr(4'h9, 32'h40);
    wr(4'h8, 32'h8000_0000);
    dma_req = 2'b11; #1;
    chk("R9 only ch0 strobe", {28'h0, per_rd_stb, per_wr_stb}, 32'h4);
    repeat (2) tick();
    rd(4'hA, rv); chk("R9 ch1 waited", rv, 32'h40);
    rd(4'h2, rv); chk("R9 ch0 moved", rv, 32'h25);
    dma_req = 2'b10;
    tick();
    dma_req = 2'b00;
    rd(4'hA, rv); chk("R9 ch1 then served", rv, 32'h41);

    // R4 R12 count, reload shadow and read rule
    wr(4'h3, 32'd5);
    wr(4'hB, 32'd3);
    rd(4'hB, rv); chk("R12 ch1 enabled count", rv, 32'd3);
    rd(4'hC, rv); chk("R4 reload1", rv, 32'd3);
    rd(4'h4, rv); chk("R4 reload0", rv, 32'd5);
    wr(4'h8, 32'h0000_0000);
    rd(4'hB, rv); chk("R12 ch1 disabled count", rv, 32'd5);
    rd(4'h3, rv); chk("R12 ch0 count", rv, 32'd5);

    // R10 video blocks with auto-reload
    wr(4'hB, 32'd2);
    wr(4'h9, 32'h80);
    wr(4'h8, 32'hA000_0000);
    chk("R11 not blanked", {31'h0, vid_blank}, 32'h0);
    dma_req = 2'b10;
    repeat (64) tick();
    dma_req = 2'b00;
    rd(4'hB, rv); chk("R10 count after block", rv, 32'd1);
    rd(4'hA, rv); chk("R10 cur after block", rv, 32'hC0);
    dma_req = 2'b10;
    repeat (64) tick();
    dma_req = 2'b00;
    rd(4'hB, rv); chk("R10 count reloaded", rv, 32'd2);
    rd(4'hA, rv); chk("R10 addr restarted", rv, 32'h80);

    // R11 frame start
    dma_req = 2'b10;
    repeat (64) tick();
    dma_req = 2'b00;
    vid_frame = 1'b1; tick(); vid_frame = 1'b0;
    rd(4'hB, rv); chk("R11 frame restores count", rv, 32'd2);
    wr(4'h8, 32'h8000_0000);
    chk("R11 blanked without auto", {31'h0, vid_blank}, 32'h1);
    vid_frame = 1'b1; tick(); vid_frame = 1'b0;
    rd(4'hB, rv); chk("R11 frame zeroes count", rv, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule